// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog that counts cycles of a slow, low-power clock. A prescaler divides that clock by one of two powers of two, and a postscaler then divides the prescaler output by 2^n, where a 4-bit setting picks n. When the full count runs out, the watchdog times out. In run mode a timeout raises a one-cycle reset request. While the device sleeps or idles, the same timeout raises a one-cycle wake-up request instead. Every timeout sets a sticky flag, which stays set until software clears it.

The counts start again from zero on each of these one-cycle events: a device reset, the end of a clock switch, a power-save command, an exit from sleep or idle, and a clear command. When the window-disable strap is low, a clear is legal only in the last quarter of the period. A clear that arrives earlier is treated as a failure and raises a reset request. The watchdog runs whenever the hardware-enable strap is high. When the strap is low, a software-enable bit controls it, and a device reset clears that bit. While the watchdog is disabled its counts stay at zero.

All inputs are one-cycle pulses or levels that are synchronous to the watchdog clock. The prescaler and postscaler settings should be changed only while the watchdog is disabled, or in the same cycle as a restart event other than a clear.

Top module: `wdt_top`

## Requirements
- R1: After `rst_n` is released, `rst_req`, `wake_req` and `wdt_flag` are 0 and the software-enable bit is 0.
- R2: The prescaler divides by 2^PRE_SHORT_LOG2 when `pre_long` is 0 and by 2^PRE_LONG_LOG2 when `pre_long` is 1.
- R3: With divide D and `post_sel` = n, the first timeout request goes high exactly D*2^n clock edges after the edge on which a restart event was taken, provided no other event comes in between.
- R4: Each of `dev_rst_evt`, `clk_sw_evt`, `pwrsav_evt`, `wake_exit_evt` and an accepted `clr_evt` sets both counts to zero. In that cycle no timeout is taken.
- R5: When `hw_en` is 1 the watchdog runs. When `hw_en` is 0 it runs only while the software-enable bit is 1. A pulse on `sw_en_we` loads that bit from `sw_en_wdata`, and `dev_rst_evt` clears it, taking precedence over the load.
- R6: When `win_dis` is 0, a `clr_evt` is early if the elapsed cycles since the last restart, counted at prescaler granularity, are fewer than 3/4 of D*2^n. An early clear gives a one-cycle `rst_req` on the next edge, sets `wdt_flag` and restarts the counts. When `win_dis` is 1, every clear is accepted.
- R7: A timeout while `sleep_st` is 1 gives a one-cycle `wake_req` and no `rst_req`. The two requests are never high together.
- R8: A timeout while `sleep_st` is 0 gives a one-cycle `rst_req`.
- R9: `wdt_flag` is set by every timeout and by every early clear. It is cleared only by `flag_clr`, and a set in the same cycle wins over the clear.
- R10: While the watchdog is disabled, both counts are held at zero and no request is raised, even for an early clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock from the slow oscillator |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| hw_en | input | 1 | Hardware-enable strap; 1 forces the watchdog on |
| sw_en_we | input | 1 | Write strobe for the software-enable bit |
| sw_en_wdata | input | 1 | Value written to the software-enable bit |
| win_dis | input | 1 | Window-disable strap; 1 allows a clear at any time |
| pre_long | input | 1 | Prescaler select: 0 short divide, 1 long divide |
| post_sel | input | POST_SEL_W | Postscaler exponent n; the divide is 2^n |
| clr_evt | input | 1 | Clear command pulse |
| flag_clr | input | 1 | Software clear of the timeout flag |
| sleep_st | input | 1 | Device is in sleep or idle |
| dev_rst_evt | input | 1 | Device reset event pulse |
| clk_sw_evt | input | 1 | Clock-switch completion pulse |
| pwrsav_evt | input | 1 | Power-save command pulse |
| wake_exit_evt | input | 1 | Exit from sleep or idle pulse |
| rst_req | output | 1 | One-cycle device reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| wdt_flag | output | 1 | Sticky timeout flag |

## Verification
The hardest cases to reach from the ports are those that need an exact cycle position inside a long count. Examples are a clear one cycle before or exactly at the window edge, and a flag clear in the same cycle as a timeout. The bench shrinks the prescaler parameters so that a period lasts only tens of cycles. It then pulses a restart event and waits a computed number of idle cycles, so that the position of every clear or flag clear is known. Random phases mix sleep changes, enable changes, configuration changes together with clock-switch events, and clears at random points, and a cycle model in the bench checks every output on every cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // last prescaler count before it wraps: 2^shift - 1
  function automatic logic [31:0] pre_last_f(input logic long_sel, input int ps_log2,
                                             input int pl_log2);
    int sh;
    sh = long_sel ? pl_log2 : ps_log2;
    return (32'd1 << sh) - 32'd1;
  endfunction

  // last postscaler count before timeout: 2^sel - 1
  function automatic logic [31:0] post_last_f(input logic [31:0] sel);
    return (32'd1 << sel) - 32'd1;
  endfunction

  // elapsed = post*D + pre must be at least 3/4 of D*2^sel
  function automatic logic win_open_f(input logic [31:0] post, input logic [31:0] pre,
                                      input logic [31:0] sel, input logic long_sel,
                                      input int ps_log2, input int pl_log2);
    int          sh;
    logic [63:0] elapsed;
    logic [63:0] thresh;
    sh      = long_sel ? pl_log2 : ps_log2;
    elapsed = ({32'd0, post} << sh) | {32'd0, pre};
    thresh  = 64'd3 << (sel + 32'(sh) - 32'd2);
    return elapsed >= thresh;
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int PS_LOG2 = 5,
  parameter int PL_LOG2 = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic               long_sel,
  output logic [PL_LOG2-1:0] cnt,
  output logic               tick
);
  localparam int W = PL_LOG2;

  logic [W-1:0] last_v;

  assign last_v = W'(pre_last_f(long_sel, PS_LOG2, PL_LOG2));
  assign tick   = run && !restart && (cnt == last_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || restart || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_postscaler.sv
module wdt_postscaler
  import wdt_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter int W     = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     cnt,
  output logic             term
);
  logic [W-1:0] last_v;

  assign last_v = W'(post_last_f(32'(sel)));
  assign term   = tick && (cnt == last_v);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!run || restart || term) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_en,
  input  logic sw_en_we,
  input  logic sw_en_wdata,
  input  logic dev_rst_evt,
  input  logic clk_sw_evt,
  input  logic pwrsav_evt,
  input  logic wake_exit_evt,
  input  logic clr_evt,
  input  logic win_dis,
  input  logic win_ok,
  input  logic sleep_st,
  input  logic timeout_evt,
  input  logic flag_clr,
  output logic wd_en,
  output logic restart_evt,
  output logic early_clr_evt,
  output logic rst_req,
  output logic wake_req,
  output logic wdt_flag
);
  logic sw_en_q;

  assign wd_en         = hw_en | sw_en_q;
  assign restart_evt   = dev_rst_evt | clk_sw_evt | pwrsav_evt | wake_exit_evt | clr_evt;
  assign early_clr_evt = wd_en && clr_evt && !win_dis && !win_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en_q <= 1'b0;
    end else if (dev_rst_evt) begin
      sw_en_q <= 1'b0;
    end else if (sw_en_we) begin
      sw_en_q <= sw_en_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
      wdt_flag <= 1'b0;
    end else begin
      rst_req  <= early_clr_evt | (timeout_evt & ~sleep_st);
      wake_req <= timeout_evt & sleep_st;
      if (early_clr_evt || timeout_evt) begin
        wdt_flag <= 1'b1;
      end else if (flag_clr) begin
        wdt_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int PRE_SHORT_LOG2 = 5,
  parameter int PRE_LONG_LOG2  = 7,
  parameter int POST_SEL_W     = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hw_en,
  input  logic                  sw_en_we,
  input  logic                  sw_en_wdata,
  input  logic                  win_dis,
  input  logic                  pre_long,
  input  logic [POST_SEL_W-1:0] post_sel,
  input  logic                  clr_evt,
  input  logic                  flag_clr,
  input  logic                  sleep_st,
  input  logic                  dev_rst_evt,
  input  logic                  clk_sw_evt,
  input  logic                  pwrsav_evt,
  input  logic                  wake_exit_evt,
  output logic                  rst_req,
  output logic                  wake_req,
  output logic                  wdt_flag
);
  localparam int PRE_W  = PRE_LONG_LOG2;
  localparam int POST_W = (1 << POST_SEL_W) - 1;

  // named internal events, visible to the bound checker
  logic              wd_en;
  logic              restart_evt;
  logic              early_clr_evt;
  logic              timeout_evt;
  logic              pre_tick;
  logic              win_ok;
  logic [PRE_W-1:0]  pre_cnt;
  logic [POST_W-1:0] post_cnt;

  assign win_ok = win_open_f(32'(post_cnt), 32'(pre_cnt), 32'(post_sel), pre_long,
                             PRE_SHORT_LOG2, PRE_LONG_LOG2);

  wdt_prescaler #(
    .PS_LOG2(PRE_SHORT_LOG2),
    .PL_LOG2(PRE_LONG_LOG2)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (wd_en),
    .restart (restart_evt),
    .long_sel(pre_long),
    .cnt     (pre_cnt),
    .tick    (pre_tick)
  );

  wdt_postscaler #(
    .SEL_W(POST_SEL_W),
    .W    (POST_W)
  ) u_post (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (wd_en),
    .restart(restart_evt),
    .tick   (pre_tick),
    .sel    (post_sel),
    .cnt    (post_cnt),
    .term   (timeout_evt)
  );

  wdt_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .hw_en        (hw_en),
    .sw_en_we     (sw_en_we),
    .sw_en_wdata  (sw_en_wdata),
    .dev_rst_evt  (dev_rst_evt),
    .clk_sw_evt   (clk_sw_evt),
    .pwrsav_evt   (pwrsav_evt),
    .wake_exit_evt(wake_exit_evt),
    .clr_evt      (clr_evt),
    .win_dis      (win_dis),
    .win_ok       (win_ok),
    .sleep_st     (sleep_st),
    .timeout_evt  (timeout_evt),
    .flag_clr     (flag_clr),
    .wd_en        (wd_en),
    .restart_evt  (restart_evt),
    .early_clr_evt(early_clr_evt),
    .rst_req      (rst_req),
    .wake_req     (wake_req),
    .wdt_flag     (wdt_flag)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int PRE_W  = 7,
  parameter int POST_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wd_en,
  input logic              restart_evt,
  input logic              early_clr_evt,
  input logic              timeout_evt,
  input logic              sleep_st,
  input logic              flag_clr,
  input logic              rst_req,
  input logic              wake_req,
  input logic              wdt_flag,
  input logic [PRE_W-1:0]  pre_cnt,
  input logic [POST_W-1:0] post_cnt
);
  p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_evt && wd_en) |=> (pre_cnt == '0 && post_cnt == '0));

  p_early_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    early_clr_evt |=> (rst_req && wdt_flag));

  p_wake_in_sleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> $past(sleep_st));

  p_req_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req && wake_req));

  p_run_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_evt && !sleep_st) |=> rst_req);

  p_flag_on_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req || wake_req) |-> wdt_flag);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_flag && !flag_clr) |=> wdt_flag);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |=> (!rst_req && !wake_req && pre_cnt == '0 && post_cnt == '0));
endmodule

bind wdt_top wdt_chk #(
  .PRE_W (PRE_W),
  .POST_W(POST_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wd_en        (wd_en),
  .restart_evt  (restart_evt),
  .early_clr_evt(early_clr_evt),
  .timeout_evt  (timeout_evt),
  .sleep_st     (sleep_st),
  .flag_clr     (flag_clr),
  .rst_req      (rst_req),
  .wake_req     (wake_req),
  .wdt_flag     (wdt_flag),
  .pre_cnt      (pre_cnt),
  .post_cnt     (post_cnt)
);

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
  localparam int PS = 2;
  localparam int PL = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hw_en = 1'b0, sw_en_we = 1'b0, sw_en_wdata = 1'b0, win_dis = 1'b1;
  logic       pre_long = 1'b0;
  logic [3:0] post_sel = 4'd2;
  logic       clr_evt = 1'b0, flag_clr = 1'b0, sleep_st = 1'b0;
  logic       dev_rst_evt = 1'b0, clk_sw_evt = 1'b0, pwrsav_evt = 1'b0, wake_exit_evt = 1'b0;
  logic       rst_req, wake_req, wdt_flag;

  int total_checks = 0;
  int bad_checks = 0;
  int cyc = 0;

  // bench reference model state
  int el = 0;
  bit m_swen = 0, m_rst = 0, m_wake = 0, m_flag = 0;

  always #10 clk = ~clk;

  wdt_top #(
    .PRE_SHORT_LOG2(PS),
    .PRE_LONG_LOG2 (PL),
    .POST_SEL_W    (4)
  ) dut (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_en), .sw_en_we(sw_en_we), .sw_en_wdata(sw_en_wdata),
    .win_dis(win_dis), .pre_long(pre_long), .post_sel(post_sel), .clr_evt(clr_evt),
    .flag_clr(flag_clr), .sleep_st(sleep_st), .dev_rst_evt(dev_rst_evt),
    .clk_sw_evt(clk_sw_evt), .pwrsav_evt(pwrsav_evt), .wake_exit_evt(wake_exit_evt),
    .rst_req(rst_req), .wake_req(wake_req), .wdt_flag(wdt_flag)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total_checks++;
    if (!ok) begin
      bad_checks++;
      $display("FAIL %s: act=%0d exp=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int period_len();
    return (1 << (pre_long ? PL : PS)) << post_sel;
  endfunction

  task automatic model_update();
    bit en, to, r, w, rs;
    int t;
    en = hw_en | m_swen;
    to = 0; r = 0; w = 0;
    t  = period_len();
    rs = dev_rst_evt | clk_sw_evt | pwrsav_evt | wake_exit_evt | clr_evt;
    if (!en) el = 0;
    else if (clr_evt && !win_dis && el * 4 < 3 * t) begin r = 1; to = 1; el = 0; end
    else if (rs) el = 0;
    else if (el == t - 1) begin to = 1; if (sleep_st) w = 1; else r = 1; el = 0; end
    else el++;
    if (dev_rst_evt) m_swen = 0;
    else if (sw_en_we) m_swen = sw_en_wdata;
    if (to) m_flag = 1;
    else if (flag_clr) m_flag = 0;
    m_rst = r;
    m_wake = w;
  endtask

  // one clock: inputs already set at negedge, model updated at the edge, outputs compared after
  task automatic step();
    @(posedge clk);
    model_update();
    @(negedge clk);
    check(rst_req == m_rst, "R8 rst_req vs model", int'(rst_req), int'(m_rst));
    check(wake_req == m_wake, "R7 wake_req vs model", int'(wake_req), int'(m_wake));
    check(wdt_flag == m_flag, "R9 wdt_flag vs model", int'(wdt_flag), int'(m_flag));
    clr_evt = 0; flag_clr = 0; sw_en_we = 0; dev_rst_evt = 0;
    clk_sw_evt = 0; pwrsav_evt = 0; wake_exit_evt = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // pulse a restart event of the given kind, then count edges to the first request
  task automatic measure(input int kind, input int exp, input string tag, input bit want_wake);
    int n;
    bit got_wake;
    case (kind)
      0: clk_sw_evt = 1;
      1: pwrsav_evt = 1;
      2: wake_exit_evt = 1;
      3: dev_rst_evt = 1;
      default: clr_evt = 1;
    endcase
    step();
    n = 0;
    got_wake = 0;
    while (n < exp + 20) begin
      step();
      n++;
      if (rst_req || wake_req) begin
        got_wake = wake_req;
        break;
      end
    end
    check(n == exp, tag, n, exp);
    check(got_wake == want_wake, tag, int'(got_wake), int'(want_wake));
  endtask

  task automatic count_quiet(input int n, input string tag);
    int seen;
    seen = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (rst_req || wake_req) seen++;
    end
    check(seen == 0, tag, seen, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      bad_checks++;
      total_checks++;
      $display("FAIL watchdog: act=%0d exp=%0d", cyc, 200000);
      $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(rst_req == 0, "R1 rst_req after reset", int'(rst_req), 0);
    check(wake_req == 0, "R1 wake_req after reset", int'(wake_req), 0);
    check(wdt_flag == 0, "R1 wdt_flag after reset", int'(wdt_flag), 0);
    // R1/R5: software enable starts at 0, so nothing happens with the strap low
    count_quiet(40, "R1 no request with soft enable at reset value");

    // R3 / R2: timeout periods
    hw_en = 1; win_dis = 1;
    pre_long = 0; post_sel = 4'd2; measure(0, 16, "R3 short n=2 period", 0);
    pre_long = 0; post_sel = 4'd0; measure(0, 4, "R3 short n=0 period", 0);
    pre_long = 1; post_sel = 4'd1; measure(0, 16, "R2 long n=1 period", 0);
    pre_long = 1; post_sel = 4'd2; measure(0, 32, "R2 long n=2 period", 0);
    pre_long = 0; post_sel = 4'd3; measure(0, 32, "R2 short n=3 period", 0);

    // R4: each restart source, after a partial count
    pre_long = 0; post_sel = 4'd2;
    for (int k = 0; k < 5; k++) begin
      idle(7);
      measure(k, 16, "R4 restart source resets counts", 0);
    end

    // R7: timeout while asleep wakes instead of resetting
    sleep_st = 1;
    measure(0, 16, "R7 sleep timeout wakes", 1);
    sleep_st = 0; wake_exit_evt = 1; step();

    // R9: flag clear, then collision of clear with a timeout
    flag_clr = 1; step();
    check(wdt_flag == 0, "R9 flag cleared by software", int'(wdt_flag), 0);
    clk_sw_evt = 1; step();
    idle(15);
    flag_clr = 1; step();
    check(wdt_flag == 1, "R9 set beats clear", int'(wdt_flag), 1);
    idle(5);
    check(wdt_flag == 1, "R9 flag stays set", int'(wdt_flag), 1);

    // R6: window boundary, period 16, threshold 12
    win_dis = 0;
    clk_sw_evt = 1; step(); idle(11);
    clr_evt = 1; step();
    check(rst_req == 1, "R6 clear one cycle early", int'(rst_req), 1);
    clk_sw_evt = 1; step(); idle(12);
    clr_evt = 1; step();
    check(rst_req == 0, "R6 clear at window start", int'(rst_req), 0);
    pre_long = 0; post_sel = 4'd1; clk_sw_evt = 1; step(); idle(5);
    clr_evt = 1; step();
    check(rst_req == 1, "R6 n=1 clear before 6", int'(rst_req), 1);
    clk_sw_evt = 1; step(); idle(6);
    clr_evt = 1; step();
    check(rst_req == 0, "R6 n=1 clear at 6", int'(rst_req), 0);
    win_dis = 1; post_sel = 4'd2;
    clk_sw_evt = 1; step(); idle(1);
    clr_evt = 1; step();
    check(rst_req == 0, "R6 window disabled accepts early clear", int'(rst_req), 0);

    // R10 / R5: enable sources
    hw_en = 0; win_dis = 0;
    count_quiet(40, "R10 disabled makes no request");
    clr_evt = 1; step();
    check(rst_req == 0, "R10 early clear ignored when disabled", int'(rst_req), 0);
    sw_en_we = 1; sw_en_wdata = 1; step();
    idle(15);
    check(rst_req == 0, "R5 soft enable counting", int'(rst_req), 0);
    step();
    check(rst_req == 1, "R5 soft enable timeout", int'(rst_req), 1);
    dev_rst_evt = 1; sw_en_we = 1; sw_en_wdata = 1; step();
    count_quiet(40, "R5 device reset clears soft enable");
    hw_en = 1;

    // random phase against the model
    for (int i = 0; i < 5000; i++) begin
      if ($urandom_range(0, 24) == 0) clr_evt = 1;
      if ($urandom_range(0, 39) == 0) flag_clr = 1;
      if ($urandom_range(0, 299) == 0) dev_rst_evt = 1;
      if ($urandom_range(0, 149) == 0) pwrsav_evt = 1;
      if ($urandom_range(0, 199) == 0) begin sw_en_we = 1; sw_en_wdata = 1'($urandom_range(0, 1)); end
      if ($urandom_range(0, 299) == 0) hw_en = ~hw_en;
      if ($urandom_range(0, 299) == 0) win_dis = ~win_dis;
      if ($urandom_range(0, 99) == 0) begin
        if (sleep_st) wake_exit_evt = 1;
        sleep_st = ~sleep_st;
      end
      if (!clr_evt && $urandom_range(0, 149) == 0) begin
        clk_sw_evt = 1;
        pre_long = 1'($urandom_range(0, 1));
        post_sel = 4'($urandom_range(0, 3));
      end
      step();
    end

    $display("test done: total=%0d bad=%0d", total_checks, bad_checks);
    $finish;
  end
endmodule